// File: doc/BRIEF.md
# Prioritised Interrupt Controller Register Block

This block collects 64 level-sensitive interrupt lines and presents two requests to a processor: a normal request and a fast request. Each line has an enable bit, a routing bit and a 4-bit priority, and software may also force any line active. A line that is active, enabled and routed to the normal path takes part in a priority search. The winner's number and priority can be read from a vector/status word. The normal request is raised only when the winner's priority clears a programmable threshold. Lines routed to the fast path bypass priorities: the fast request is the OR of them all, and a second vector word names the highest-numbered one.

Software reaches all state through a 32-bit register port that carries a request channel and a response channel, each with valid/ready. A request is taken in a cycle where `req_valid` and `req_ready` are both high. Exactly one response follows each request, in order, and carries read data, or zero for a write. While a response waits on `rsp_ready` low, `req_ready` stays low and `rsp_rdata` holds still, so back-pressure on the response channel stalls the request channel. Writes take effect at the clock edge that accepts them. The two interrupt outputs follow the source inputs and the registers combinationally.

Register map (byte offsets): 0x00 control (plain 32-bit storage), 0x04 threshold (5 bits), 0x08 enable-by-number, 0x0C disable-by-number, 0x10/0x14 enable upper/lower, 0x18/0x1C routing upper/lower, 0x20..0x3C priority words, 0x40 normal vector, 0x44 fast vector, 0x48/0x4C raw lines upper/lower, 0x50/0x54 force upper/lower, 0x58/0x5C normal pending upper/lower, 0x60/0x64 fast pending upper/lower.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, control reads 0, the threshold reads 0x1F, every enable, routing and force bit is 0, every priority is 0, and both interrupt outputs are low.
- R2: A write of n to offset 0x08 sets enable bit n, and a write of n to offset 0x0C clears it. Only wdata[5:0] is used and no other enable bit changes. Both offsets read back as 0.
- R3: In every upper/lower pair, line n sits at bit n mod 32. The lower word holds lines 0–31 and the upper word holds lines 32–63.
- R4: Line n's priority is bits [4*(n%8)+3 : 4*(n%8)] of the word at offset 0x20 + 4*(7 - n/8). Line 63 is therefore at 0x20 bits 31:28, and line 0 is at 0x3C bits 3:0.
- R5: A line is active when its raw input or its force bit is 1. It is normal-pending when active, enabled and routing bit 0. It is fast-pending when active, enabled and routing bit 1.
- R6: The normal request is high exactly when threshold bit 4 is 0 and some normal-pending line has a priority strictly greater than threshold bits 3:0.
- R7: The normal vector (0x40) holds the winning line number in bits 31:16 and its priority in bits 3:0, with bits 15:4 zero. The winner is the highest priority, and a tie goes to the higher line number. The vector does not depend on the threshold. With nothing normal-pending it reads 0xFFFFFFFF.
- R8: The fast request is high when any line is fast-pending. The fast vector (0x44) holds the highest-numbered fast-pending line in bits 31:16 with bits 15:0 zero, and reads 0xFFFF0000 when none is pending.
- R9: Writes to the vector, raw-line and pending offsets change nothing, and neither do writes to unmapped offsets. Unmapped offsets read 0.
- R10: Each accepted request yields one response, in order. While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and `rsp_rdata` is stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 7 | Byte offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | 32 | Read data, 0 for writes |
| src_i | input | 64 | Level-sensitive interrupt lines |
| irq_norm | output | 1 | Normal interrupt request |
| irq_fast | output | 1 | Fast interrupt request |

## Verification
Every cycle, the assertions check these properties:
- the response handshake holds its data, and it stalls the request side under back-pressure;
- the normal and fast pending sets never overlap;
- a set threshold bit 4 silences the normal request;
- neither request is raised with its pending set empty;
- an enable-by-number write lands on the named bit.

Only the bench's scenarios can show the following:
- the priority search order and its tie-break toward higher line numbers;
- the strict comparison against the threshold;
- the reversed placement of the priority words;
- that writes to read-only offsets leave the readable state unchanged.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int NSRC  = 64;
  localparam int PW    = 4;
  localparam int AW    = 7;
  localparam int DW    = 32;
  localparam int IW    = $clog2(NSRC);
  localparam int PWORDS = (NSRC * PW) / DW;

  localparam logic [AW-1:0] OFS_CTRL  = 7'h00;
  localparam logic [AW-1:0] OFS_THR   = 7'h04;
  localparam logic [AW-1:0] OFS_ENNUM = 7'h08;
  localparam logic [AW-1:0] OFS_DSNUM = 7'h0C;
  localparam logic [AW-1:0] OFS_ENHI  = 7'h10;
  localparam logic [AW-1:0] OFS_ENLO  = 7'h14;
  localparam logic [AW-1:0] OFS_RTHI  = 7'h18;
  localparam logic [AW-1:0] OFS_RTLO  = 7'h1C;
  localparam logic [AW-1:0] OFS_NVEC  = 7'h40;
  localparam logic [AW-1:0] OFS_FVEC  = 7'h44;
  localparam logic [AW-1:0] OFS_RAWHI = 7'h48;
  localparam logic [AW-1:0] OFS_RAWLO = 7'h4C;
  localparam logic [AW-1:0] OFS_FRHI  = 7'h50;
  localparam logic [AW-1:0] OFS_FRLO  = 7'h54;
  localparam logic [AW-1:0] OFS_NPHI  = 7'h58;
  localparam logic [AW-1:0] OFS_NPLO  = 7'h5C;
  localparam logic [AW-1:0] OFS_FPHI  = 7'h60;
  localparam logic [AW-1:0] OFS_FPLO  = 7'h64;

  // priority words occupy 0x20..0x3C, word-aligned
  function automatic logic is_prio_ofs(input logic [AW-1:0] a);
    return (a[6:5] == 2'b01) && (a[1:0] == 2'b00);
  endfunction

  // reversed placement: group g lives at 0x20 + 4*(7-g)
  function automatic logic [2:0] prio_group(input logic [AW-1:0] a);
    return 3'd7 - a[4:2];
  endfunction
endpackage

// File: rtl/pic_regs.sv
module pic_regs
  import pic_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [AW-1:0]        addr,
  input  logic [DW-1:0]        wdata,
  output logic [DW-1:0]        ctrl_q,
  output logic [4:0]           thr_q,
  output logic [NSRC-1:0]      en_q,
  output logic [NSRC-1:0]      route_q,
  output logic [NSRC-1:0]      force_q,
  output logic [NSRC*PW-1:0]   prio_q
);
  localparam int HALF = NSRC / 2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      thr_q   <= 5'h1F;
      en_q    <= '0;
      route_q <= '0;
      force_q <= '0;
      prio_q  <= '0;
    end else if (wr_en) begin
      case (addr)
        OFS_CTRL:  ctrl_q <= wdata;
        OFS_THR:   thr_q  <= wdata[4:0];
        OFS_ENNUM: en_q[wdata[IW-1:0]] <= 1'b1;
        OFS_DSNUM: en_q[wdata[IW-1:0]] <= 1'b0;
        OFS_ENHI:  en_q[NSRC-1:HALF]    <= wdata;
        OFS_ENLO:  en_q[HALF-1:0]       <= wdata;
        OFS_RTHI:  route_q[NSRC-1:HALF] <= wdata;
        OFS_RTLO:  route_q[HALF-1:0]    <= wdata;
        OFS_FRHI:  force_q[NSRC-1:HALF] <= wdata;
        OFS_FRLO:  force_q[HALF-1:0]    <= wdata;
        default: begin
          if (is_prio_ofs(addr))
            prio_q[prio_group(addr)*DW +: DW] <= wdata;
        end
      endcase
    end
  end
endmodule

// File: rtl/pic_route.sv
module pic_route
  import pic_pkg::*;
(
  input  logic [NSRC-1:0] src_i,
  input  logic [NSRC-1:0] force_q,
  input  logic [NSRC-1:0] en_q,
  input  logic [NSRC-1:0] route_q,
  output logic [NSRC-1:0] norm_pend,
  output logic [NSRC-1:0] fast_pend,
  output logic            fast_any,
  output logic [IW-1:0]   fast_idx
);
  logic [NSRC-1:0] live;

  assign live      = (src_i | force_q) & en_q;
  assign norm_pend = live & ~route_q;
  assign fast_pend = live & route_q;
  assign fast_any  = |fast_pend;

  // ascending scan: the last hit is the highest-numbered line
  always_comb begin
    fast_idx = '0;
    for (int i = 0; i < NSRC; i++)
      if (fast_pend[i]) fast_idx = IW'(i);
  end
endmodule

// File: rtl/pic_prio_search.sv
module pic_prio_search
  import pic_pkg::*;
(
  input  logic [NSRC-1:0]    pend,
  input  logic [NSRC*PW-1:0] prio_q,
  output logic               found,
  output logic [IW-1:0]      win_idx,
  output logic [PW-1:0]      win_prio
);
  // ascending scan with >= so an equal priority moves the winner upward
  always_comb begin
    found    = 1'b0;
    win_idx  = '0;
    win_prio = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (pend[i] && (!found || prio_q[i*PW +: PW] >= win_prio)) begin
        found    = 1'b1;
        win_idx  = IW'(i);
        win_prio = prio_q[i*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic [6:0]      req_addr,
  input  logic [31:0]     req_wdata,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [31:0]     rsp_rdata,
  input  logic [63:0]     src_i,
  output logic            irq_norm,
  output logic            irq_fast
);
  localparam int HALF = NSRC / 2;

  logic [DW-1:0]      ctrl_q;
  logic [4:0]         thr_q;
  logic [NSRC-1:0]    en_q, route_q, force_q;
  logic [NSRC*PW-1:0] prio_q;
  logic [NSRC-1:0]    norm_pend, fast_pend;
  logic               fast_any, norm_found;
  logic [IW-1:0]      fast_idx, norm_idx;
  logic [PW-1:0]      norm_prio;
  logic               accept;
  logic [DW-1:0]      rd_mux;
  logic               rsp_valid_q;
  logic [DW-1:0]      rsp_data_q;

  assign req_ready = !rsp_valid_q || rsp_ready;
  assign accept    = req_valid && req_ready;

  pic_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(accept && req_write),
    .addr(req_addr), .wdata(req_wdata),
    .ctrl_q(ctrl_q), .thr_q(thr_q), .en_q(en_q), .route_q(route_q),
    .force_q(force_q), .prio_q(prio_q)
  );

  pic_route u_route (
    .src_i(src_i), .force_q(force_q), .en_q(en_q), .route_q(route_q),
    .norm_pend(norm_pend), .fast_pend(fast_pend),
    .fast_any(fast_any), .fast_idx(fast_idx)
  );

  pic_prio_search u_search (
    .pend(norm_pend), .prio_q(prio_q),
    .found(norm_found), .win_idx(norm_idx), .win_prio(norm_prio)
  );

  assign irq_norm = norm_found && !thr_q[4] && (norm_prio > thr_q[3:0]);
  assign irq_fast = fast_any;

  always_comb begin
    rd_mux = '0;
    case (req_addr)
      OFS_CTRL:  rd_mux = ctrl_q;
      OFS_THR:   rd_mux = {{(DW-5){1'b0}}, thr_q};
      OFS_ENHI:  rd_mux = en_q[NSRC-1:HALF];
      OFS_ENLO:  rd_mux = en_q[HALF-1:0];
      OFS_RTHI:  rd_mux = route_q[NSRC-1:HALF];
      OFS_RTLO:  rd_mux = route_q[HALF-1:0];
      OFS_NVEC:  rd_mux = norm_found ?
                   {{(16-IW){1'b0}}, norm_idx, {(16-PW){1'b0}}, norm_prio} : '1;
      OFS_FVEC:  rd_mux = fast_any ?
                   {{(16-IW){1'b0}}, fast_idx, 16'h0000} : 32'hFFFF_0000;
      OFS_RAWHI: rd_mux = src_i[NSRC-1:HALF];
      OFS_RAWLO: rd_mux = src_i[HALF-1:0];
      OFS_FRHI:  rd_mux = force_q[NSRC-1:HALF];
      OFS_FRLO:  rd_mux = force_q[HALF-1:0];
      OFS_NPHI:  rd_mux = norm_pend[NSRC-1:HALF];
      OFS_NPLO:  rd_mux = norm_pend[HALF-1:0];
      OFS_FPHI:  rd_mux = fast_pend[NSRC-1:HALF];
      OFS_FPLO:  rd_mux = fast_pend[HALF-1:0];
      default: begin
        if (is_prio_ofs(req_addr))
          rd_mux = prio_q[prio_group(req_addr)*DW +: DW];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else if (accept) begin
      rsp_valid_q <= 1'b1;
      rsp_data_q  <= req_write ? '0 : rd_mux;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_data_q;
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk
  import pic_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            req_write,
  input logic [6:0]      req_addr,
  input logic [31:0]     req_wdata,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [31:0]     rsp_rdata,
  input logic            irq_norm,
  input logic            irq_fast,
  input logic [4:0]      thr_q,
  input logic [NSRC-1:0] en_q,
  input logic [NSRC-1:0] norm_pend,
  input logic [NSRC-1:0] fast_pend
);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  p_disjoint_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (norm_pend & fast_pend) == '0);

  p_thr_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    thr_q[4] |-> !irq_norm);

  p_norm_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_norm |-> (norm_pend != '0));

  p_fast_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_fast |-> (fast_pend != '0));

  p_ennum_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write && req_addr == OFS_ENNUM)
      |=> en_q[$past(req_wdata[IW-1:0])]);
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk u_chk (.*);

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [6:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, irq_norm, irq_fast;
  logic [31:0] rsp_rdata;
  logic [63:0] src = '0;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference state, kept from the requirements
  logic [31:0] m_ctrl;
  logic [4:0]  m_thr;
  logic [63:0] m_en, m_rt, m_fr;
  logic [3:0]  m_prio [64];

  logic [31:0] exp_q [$];
  string       tag_q [$];

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .src_i(src), .irq_norm(irq_norm), .irq_fast(irq_fast)
  );

  always #5 clk = ~clk;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] npend();
    return (src | m_fr) & m_en & ~m_rt;
  endfunction
  function automatic logic [63:0] fpend();
    return (src | m_fr) & m_en & m_rt;
  endfunction

  function automatic logic [31:0] nvec();
    logic [63:0] p = npend();
    int best = -1;
    for (int i = 0; i < 64; i++)
      if (p[i] && (best < 0 || m_prio[i] >= m_prio[best])) best = i;
    if (best < 0) return 32'hFFFF_FFFF;
    return {16'(best), 12'h000, m_prio[best]};
  endfunction

  function automatic logic [31:0] fvec();
    logic [63:0] p = fpend();
    for (int i = 63; i >= 0; i--)
      if (p[i]) return {16'(i), 16'h0000};
    return 32'hFFFF_0000;
  endfunction

  function automatic logic exp_nirq();
    logic [63:0] p = npend();
    if (m_thr[4]) return 1'b0;
    for (int i = 0; i < 64; i++)
      if (p[i] && m_prio[i] > m_thr[3:0]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [31:0] exp_read(input logic [6:0] a);
    logic [31:0] w;
    int g;
    case (a)
      7'h00: return m_ctrl;
      7'h04: return {27'd0, m_thr};
      7'h10: return m_en[63:32];  7'h14: return m_en[31:0];
      7'h18: return m_rt[63:32];  7'h1C: return m_rt[31:0];
      7'h40: return nvec();       7'h44: return fvec();
      7'h48: return src[63:32];   7'h4C: return src[31:0];
      7'h50: return m_fr[63:32];  7'h54: return m_fr[31:0];
      7'h58: begin w = npend()[63:32]; return w; end
      7'h5C: begin w = npend()[31:0];  return w; end
      7'h60: begin w = fpend()[63:32]; return w; end
      7'h64: begin w = fpend()[31:0];  return w; end
      default: begin
        if (a >= 7'h20 && a <= 7'h3C && a[1:0] == 2'b00) begin
          g = 7 - ((int'(a) - 32) / 4);
          for (int k = 0; k < 8; k++) w[4*k +: 4] = m_prio[8*g + k];
          return w;
        end
        return 32'h0;
      end
    endcase
  endfunction

  task automatic model_write(input logic [6:0] a, input logic [31:0] d);
    int g;
    case (a)
      7'h00: m_ctrl = d;
      7'h04: m_thr = d[4:0];
      7'h08: m_en[d[5:0]] = 1'b1;
      7'h0C: m_en[d[5:0]] = 1'b0;
      7'h10: m_en[63:32] = d;  7'h14: m_en[31:0] = d;
      7'h18: m_rt[63:32] = d;  7'h1C: m_rt[31:0] = d;
      7'h50: m_fr[63:32] = d;  7'h54: m_fr[31:0] = d;
      default: begin
        if (a >= 7'h20 && a <= 7'h3C && a[1:0] == 2'b00) begin
          g = 7 - ((int'(a) - 32) / 4);
          for (int k = 0; k < 8; k++) m_prio[8*g + k] = d[4*k +: 4];
        end
      end
    endcase
  endtask

  // driver: pushes the expected response, then offers the request
  task automatic xact(input logic w, input logic [6:0] a, input logic [31:0] d, input string tag);
    exp_q.push_back(w ? 32'h0 : exp_read(a));
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    if (w) model_write(a, d);
    #1 req_valid = 1'b0;
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d, input string tag);
    xact(1'b1, a, d, tag);
  endtask
  task automatic rd(input logic [6:0] a, input string tag);
    xact(1'b0, a, 32'h0, tag);
  endtask

  task automatic chk_irqs(input string tag);
    @(negedge clk);
    chk({31'd0, irq_norm}, {31'd0, exp_nirq()}, {tag, " irq_norm"});
    chk({31'd0, irq_fast}, {31'd0, |fpend()}, {tag, " irq_fast"});
  endtask

  // monitor: pops and compares each response as it is taken
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R10 unexpected response actual=%h expected=none", rsp_rdata);
      end else begin
        chk(rsp_rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    m_ctrl = '0; m_thr = 5'h1F; m_en = '0; m_rt = '0; m_fr = '0;
    for (int i = 0; i < 64; i++) m_prio[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    chk_irqs("R1");
    rd(7'h00, "R1 ctrl");  rd(7'h04, "R1 thr");
    rd(7'h10, "R1 enhi");  rd(7'h14, "R1 enlo");
    rd(7'h1C, "R1 rtlo");  rd(7'h20, "R1 prio");
    rd(7'h40, "R7 nvec empty"); rd(7'h44, "R8 fvec empty");

    // R2 and R3: enable/disable by number, upper/lower split
    wr(7'h08, 32'd5, "R2 en5"); wr(7'h08, 32'd40, "R2 en40");
    wr(7'h08, 32'd63, "R2 en63");
    rd(7'h14, "R3 enlo"); rd(7'h10, "R3 enhi");
    wr(7'h0C, 32'd40, "R2 dis40"); rd(7'h10, "R2 enhi after dis");
    wr(7'h08, 32'hFFFF_FFC3, "R2 en3 upper bits ignored");
    rd(7'h14, "R2 enlo"); rd(7'h08, "R2 ennum reads 0"); rd(7'h0C, "R2 dsnum reads 0");

    // R4 reversed priority words
    wr(7'h3C, 32'h0070_0000, "R4 grp0"); wr(7'h20, 32'h9000_0000, "R4 grp7");
    rd(7'h3C, "R4 grp0 rd"); rd(7'h20, "R4 grp7 rd"); rd(7'h24, "R4 grp6 rd");

    // R6/R7 search and threshold
    wr(7'h04, 32'h0, "R6 thr0");
    @(negedge clk) src[5] = 1'b1;
    chk_irqs("R6 one line"); rd(7'h40, "R7 single winner");
    @(negedge clk) src[63] = 1'b1;
    rd(7'h40, "R7 higher prio wins");
    wr(7'h20, 32'h7000_0000, "R4 prio63=7"); rd(7'h40, "R7 tie to higher number");
    wr(7'h20, 32'h3000_0000, "R4 prio63=3"); rd(7'h40, "R7 line5 wins");
    wr(7'h04, 32'h7, "R6 thr7"); chk_irqs("R6 equal not above");
    rd(7'h40, "R7 vector ignores threshold");
    wr(7'h04, 32'h6, "R6 thr6"); chk_irqs("R6 strictly above");
    wr(7'h04, 32'h10, "R6 thr bit4"); chk_irqs("R6 blocked");

    // R5 force
    wr(7'h04, 32'h0, "R6 thr0 again");
    @(negedge clk) src = '0;
    wr(7'h54, 32'h0000_0008, "R5 force3");
    rd(7'h5C, "R5 npend lo"); rd(7'h40, "R5 forced prio0 vector");
    chk_irqs("R5 prio0 below thr0");

    // R8 fast routing
    wr(7'h18, 32'h8000_0000, "R8 route63");
    @(negedge clk) src[63] = 1'b1;
    chk_irqs("R8 fast");
    rd(7'h44, "R8 fvec"); rd(7'h60, "R8 fpend hi"); rd(7'h58, "R5 npend hi");
    rd(7'h48, "R3 raw hi");

    // R9 read-only and unmapped offsets
    wr(7'h40, 32'h1234_5678, "R9 wr nvec"); wr(7'h48, 32'h0, "R9 wr raw");
    wr(7'h58, 32'hFFFF_FFFF, "R9 wr npend"); wr(7'h70, 32'hFFFF_FFFF, "R9 wr unmapped");
    rd(7'h40, "R9 nvec"); rd(7'h48, "R9 raw"); rd(7'h58, "R9 npend");
    rd(7'h70, "R9 unmapped"); rd(7'h10, "R9 enhi"); chk_irqs("R9");

    // R10 back-pressure
    @(posedge clk); #1 rsp_ready = 1'b0;
    rd(7'h14, "R10 held read");
    repeat (3) @(negedge clk);
    chk({31'd0, req_ready}, 32'd0, "R10 req_ready low");
    chk({31'd0, rsp_valid}, 32'd1, "R10 rsp_valid held");
    @(posedge clk); #1 rsp_ready = 1'b1;
    rd(7'h00, "R10 next read");

    wr(7'h0C, 32'd63, "R2 dis63"); chk_irqs("R8 fast gone");
    repeat (4) @(negedge clk);
    chk(exp_q.size(), 32'd0, "R10 all responses seen");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule